// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the tag directory of a K-way set-associative cache and nothing else. Each clock cycle it may accept one byte address. The address is split into a byte offset, a set index and a tag. The tag is compared against every way of the indexed set, and the block reports a hit or a miss together with the way that matched or was filled. On a miss, the block writes the new tag into the chosen way, so the directory always follows the reference stream it is given.

Replacement is chosen at run time. In FIFO mode the victim is the oldest fill in the set. In LRU mode the victim is the least recently touched way. Both orderings are tracked for every set at all times, so switching the mode has no warm-up. Four saturating counters record the reference stream:

- references;
- hits;
- cold misses, which are fills into empty ways;
- replacement misses, which evict a valid way.

Keeping cold and replacement misses apart lets a trace-driven study take out the start-up transient. A flush empties the directory and clears the counters.

Top module: `cache_dir`

## Requirements
- R1: An address splits into offset bits [log2(LINE_B)-1:0], set index bits [log2(LINE_B)+log2(SETS)-1:log2(LINE_B)], and tag (all upper bits). Two addresses that differ only in offset hit the same entry. The same tag in another set is a separate entry.
- R2: A reference is accepted when req_valid_i=1 and flush_i=0. Its result (rsp_valid_o=1 with hit, way and cold flag) appears in exactly the next cycle. In every other cycle rsp_valid_o=0.
- R3: A miss in a set that has an empty way fills the lowest-numbered empty way. It reports rsp_cold_o=1 and counts as a cold miss. A hit always has rsp_cold_o=0.
- R4: With lru_sel_i=1, a miss in a full set evicts the least recently referenced way, never the most recently referenced one.
- R5: With lru_sel_i=0, a miss in a full set evicts the earliest-filled way. Hits do not alter that order.
- R6: In LRU mode, a repeating sweep of WAYS+1 distinct lines mapping to one set misses on every reference.
- R7: cnt_ref_o counts accepted references and cnt_hit_o counts hits. cnt_cold_o counts misses into empty ways, and cnt_repl_o counts misses that evict. Until saturation, references equal the sum of the other three.
- R8: flush_i=1 invalidates every way, resets both replacement orders and zeroes all counters. A request in a flush cycle is ignored: it gives no response and is not counted.
- R9: Each counter is CNT_W bits wide and holds at all-ones instead of wrapping.
- R10: A change of lru_sel_i applies from the next reference. The LRU and FIFO orders are both kept up to date regardless of the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Reference strobe |
| req_addr_i | input | ADDR_W | Byte address of the reference |
| lru_sel_i | input | 1 | 1 = LRU replacement, 0 = FIFO replacement |
| flush_i | input | 1 | Invalidate all entries and clear counters |
| rsp_valid_o | output | 1 | Result valid, one cycle after an accepted reference |
| rsp_hit_o | output | 1 | Reference hit |
| rsp_way_o | output | WAY_W | Way that was hit or filled |
| rsp_cold_o | output | 1 | Miss was filled into an empty way |
| cnt_ref_o | output | CNT_W | Accepted references |
| cnt_hit_o | output | CNT_W | Hits |
| cnt_cold_o | output | CNT_W | Cold misses |
| cnt_repl_o | output | CNT_W | Replacement misses |

## Verification
The assertions check these on every cycle:
- the one-cycle response timing and its absence after idle or flush cycles;
- that a hit never reports cold;
- the counter balance of references against hits and both miss kinds;
- that the counters are cleared by a flush and hold once saturated.

Victim selection cannot be seen from the ports in a single cycle, so only the bench scenarios show it. Those scenarios cover:
- the LRU victim against the FIFO victim for the same access history;
- the cyclic sweep that defeats LRU;
- a mode switch that reuses state already held;
- an address that differs only in offset, and a tag placed in a different set.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } repl_pol_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cd_tag_match.sv
module cd_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 19,
  localparam int WAY_W = cache_dir_pkg::idx_bits(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o      = |match;
    free_o     = ~&vld_i;
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
    // descending scan leaves the lowest empty way
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) free_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cd_rank_order.sv
module cd_rank_order #(
  parameter int SETS = 256,
  parameter int WAYS = 2,
  localparam int SET_W = cache_dir_pkg::idx_bits(SETS),
  localparam int WAY_W = cache_dir_pkg::idx_bits(WAYS),
  localparam int RNK_W = cache_dir_pkg::idx_bits(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAY_W-1:0] victim_o
);
  // rank 0 = newest, rank WAYS-1 = victim
  logic [RNK_W-1:0] rank_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= RNK_W'(w);
    end else if (clr_i) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= RNK_W'(w);
    end else if (upd_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == way_i) rank_q[set_i][w] <= '0;
        else if (rank_q[set_i][w] < rank_q[set_i][way_i])
          rank_q[set_i][w] <= rank_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rank_q[set_i][w] == RNK_W'(WAYS - 1)) victim_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cd_sat_cnt.sv
module cd_sat_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;
    else if (inc_i && (~&cnt_o))    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cache_dir.sv
module cache_dir #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int WAYS   = 2,
  parameter int LINE_B = 32,
  parameter int CNT_W  = 32,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int SET_W = cache_dir_pkg::idx_bits(SETS),
  localparam int TAG_W = ADDR_W - SET_W - OFF_W,
  localparam int WAY_W = cache_dir_pkg::idx_bits(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              lru_sel_i,
  input  logic              flush_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic              rsp_cold_o,
  output logic [CNT_W-1:0]  cnt_ref_o,
  output logic [CNT_W-1:0]  cnt_hit_o,
  output logic [CNT_W-1:0]  cnt_cold_o,
  output logic [CNT_W-1:0]  cnt_repl_o
);
  import cache_dir_pkg::*;

  logic [TAG_W-1:0]            tag_q [SETS][WAYS];
  logic [WAYS-1:0]             vld_q [SETS];
  logic [SET_W-1:0]            set_idx;
  logic [TAG_W-1:0]            req_tag;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tags;
  logic                        hit, free;
  logic [WAY_W-1:0]            hit_way, free_way, lru_vic, fifo_vic, fill_way, touch_way;
  logic                        act, miss;
  repl_pol_e                   pol;

  assign set_idx = req_addr_i[OFF_W +: SET_W];
  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign act     = req_valid_i && !flush_i;
  assign miss    = act && !hit;
  assign pol     = repl_pol_e'(lru_sel_i);

  always_comb begin
    for (int w = 0; w < WAYS; w++) rd_tags[w] = tag_q[set_idx][w];
  end

  cd_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i     (rd_tags),
    .vld_i      (vld_q[set_idx]),
    .tag_i      (req_tag),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .free_o     (free),
    .free_way_o (free_way)
  );

  always_comb begin
    if (free)                fill_way = free_way;
    else if (pol == POL_LRU) fill_way = lru_vic;
    else                     fill_way = fifo_vic;
    touch_way = hit ? hit_way : fill_way;
  end

  // recency order: every hit or fill
  cd_rank_order #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (flush_i),
    .upd_i    (act),
    .set_i    (set_idx),
    .way_i    (touch_way),
    .victim_o (lru_vic)
  );

  // fill order: misses only
  cd_rank_order #(.SETS(SETS), .WAYS(WAYS)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (flush_i),
    .upd_i    (miss),
    .set_i    (set_idx),
    .way_i    (fill_way),
    .victim_o (fifo_vic)
  );

  always_ff @(posedge clk_i) begin
    if (miss) tag_q[set_idx][fill_way] <= req_tag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (miss) begin
      vld_q[set_idx][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_cold_o  <= 1'b0;
    end else begin
      rsp_valid_o <= act;
      if (act) begin
        rsp_hit_o  <= hit;
        rsp_way_o  <= touch_way;
        rsp_cold_o <= !hit && free;
      end
    end
  end

  cd_sat_cnt #(.CNT_W(CNT_W)) u_cnt_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flush_i), .inc_i(act), .cnt_o(cnt_ref_o));
  cd_sat_cnt #(.CNT_W(CNT_W)) u_cnt_hit (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flush_i), .inc_i(act && hit), .cnt_o(cnt_hit_o));
  cd_sat_cnt #(.CNT_W(CNT_W)) u_cnt_cold (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flush_i), .inc_i(miss && free), .cnt_o(cnt_cold_o));
  cd_sat_cnt #(.CNT_W(CNT_W)) u_cnt_repl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flush_i), .inc_i(miss && !free), .cnt_o(cnt_repl_o));
endmodule

// File: rtl/cache_dir_chk.sv
module cache_dir_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             flush_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_cold_o,
  input logic [CNT_W-1:0] cnt_ref_o,
  input logic [CNT_W-1:0] cnt_hit_o,
  input logic [CNT_W-1:0] cnt_cold_o,
  input logic [CNT_W-1:0] cnt_repl_o
);
  logic [CNT_W+1:0] part_sum;
  assign part_sum = (CNT_W+2)'(cnt_hit_o) + (CNT_W+2)'(cnt_cold_o) + (CNT_W+2)'(cnt_repl_o);

  assert_rsp_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !flush_i) |=> rsp_valid_o);

  assert_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !flush_i) |=> !rsp_valid_o);

  assert_hit_not_cold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> !rsp_cold_o);

  assert_count_balance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~&cnt_ref_o) |-> (part_sum == (CNT_W+2)'(cnt_ref_o)));

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_ref_o == '0 && cnt_hit_o == '0 && cnt_cold_o == '0
                 && cnt_repl_o == '0 && !rsp_valid_o));

  assert_ref_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&cnt_ref_o) && !flush_i) |=> (&cnt_ref_o));
endmodule

bind cache_dir cache_dir_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .flush_i     (flush_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_cold_o  (rsp_cold_o),
  .cnt_ref_o   (cnt_ref_o),
  .cnt_hit_o   (cnt_hit_o),
  .cnt_cold_o  (cnt_cold_o),
  .cnt_repl_o  (cnt_repl_o)
);

// File: tb/cache_dir_test.sv
module cache_dir_test;
  localparam int AW = 16, NS = 4, NW = 3, LB = 16, CW = 6;
  localparam int WW = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, lru_sel = 1'b1, flush = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_hit, rsp_cold;
  logic [WW-1:0] rsp_way;
  logic [CW-1:0] c_ref, c_hit, c_cold, c_repl;

  always #5 clk = ~clk;

  cache_dir #(.ADDR_W(AW), .SETS(NS), .WAYS(NW), .LINE_B(LB), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .lru_sel_i(lru_sel), .flush_i(flush), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .rsp_way_o(rsp_way), .rsp_cold_o(rsp_cold), .cnt_ref_o(c_ref), .cnt_hit_o(c_hit),
    .cnt_cold_o(c_cold), .cnt_repl_o(c_repl));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model: timestamps for recency and fill age
  int m_tag [NS][NW];
  bit m_vld [NS][NW];
  int m_last [NS][NW];
  int m_fill [NS][NW];
  int now = 0;
  int e_ref = 0, e_hit = 0, e_cold = 0, e_repl = 0;

  int    exp_q [$];
  string req_q [$];

  function automatic logic [AW-1:0] mk(int tag, int set, int off);
    return AW'((tag << 6) | (set << 4) | off);
  endfunction

  function automatic int sat_inc(int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  task automatic check(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_vld[s][w] = 1'b0; m_last[s][w] = 0; m_fill[s][w] = 0; m_tag[s][w] = 0;
      end
    e_ref = 0; e_hit = 0; e_cold = 0; e_repl = 0;
  endtask

  task automatic do_ref(logic [AW-1:0] a, string rq);
    int s, t, way, hit, cold, best;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    s = int'(a[5:4]); t = int'(a[15:6]);
    hit = 0; cold = 0; way = -1;
    now++;
    for (int w = 0; w < NW; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin hit = 1; way = w; end
    if (hit == 0) begin
      for (int w = NW - 1; w >= 0; w--) if (!m_vld[s][w]) way = w;
      if (way >= 0) cold = 1;
      else begin
        best = 0;
        for (int w = 1; w < NW; w++)
          if (lru_sel ? (m_last[s][w] < m_last[s][best]) : (m_fill[s][w] < m_fill[s][best]))
            best = w;
        way = best;
      end
      m_tag[s][way] = t; m_vld[s][way] = 1'b1; m_fill[s][way] = now;
    end
    m_last[s][way] = now;
    e_ref = sat_inc(e_ref);
    if (hit != 0) e_hit = sat_inc(e_hit);
    else if (cold != 0) e_cold = sat_inc(e_cold);
    else e_repl = sat_inc(e_repl);
    exp_q.push_back((cold << 3) | (hit << 2) | way);
    req_q.push_back(rq);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic check_counts(string rq);
    check({rq, " refs"}, int'(c_ref), e_ref);
    check({rq, " hits"}, int'(c_hit), e_hit);
    check({rq, " cold"}, int'(c_cold), e_cold);
    check({rq, " repl"}, int'(c_repl), e_repl);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) check("R2 unexpected rsp_valid", 1, 0);
        else begin
          int e; string rq;
          e = exp_q.pop_front(); rq = req_q.pop_front();
          check({rq, " hit"},  int'(rsp_hit),  (e >> 2) & 1);
          check({rq, " way"},  int'(rsp_way),  e & 3);
          check({rq, " cold"}, int'(rsp_cold), (e >> 3) & 1);
        end
      end else if (exp_q.size() > 1) begin
        check("R2 missing rsp_valid", 0, 1);
        void'(exp_q.pop_front()); void'(req_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset rsp_valid", int'(rsp_valid), 0);
    check_counts("R8 reset");

    // R1/R3: offsets, sets, lowest empty way
    do_ref(mk(1, 0, 0), "R3 first fill");
    do_ref(mk(1, 0, 5), "R1 same line other offset");
    do_ref(mk(2, 0, 0), "R3 second fill");
    do_ref(mk(3, 0, 15), "R3 third fill");
    do_ref(mk(1, 1, 0), "R1 same tag other set");
    idle(2);
    check("R2 idle rsp_valid", int'(rsp_valid), 0);
    check_counts("R7 after fills");

    // R4: touch tag1 then miss; tag2 is least recent (way1)
    do_ref(mk(1, 0, 3), "R4 hit way0");
    do_ref(mk(4, 0, 0), "R4 evict lru way1");
    do_ref(mk(4, 0, 0), "R4 new line hits");
    do_ref(mk(5, 0, 0), "R4 evict lru way2");
    idle(2);

    // R5/R10: switch to FIFO in set2; hit on oldest must not save it
    lru_sel = 1'b0;
    do_ref(mk(6, 2, 0), "R5 fill way0");
    do_ref(mk(7, 2, 0), "R5 fill way1");
    do_ref(mk(8, 2, 0), "R5 fill way2");
    do_ref(mk(6, 2, 0), "R5 hit oldest");
    do_ref(mk(9, 2, 0), "R5 evict earliest fill way0");
    do_ref(mk(10, 0, 0), "R10 fifo on lru-built set");
    idle(1);
    lru_sel = 1'b1;
    do_ref(mk(11, 2, 0), "R10 back to lru");
    idle(2);
    check_counts("R7 mixed");

    // R8: flush with a request in the same cycle
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_addr = mk(1, 0, 0);
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    model_clear();
    check("R8 flush drops request", int'(rsp_valid), 0);
    check_counts("R8 after flush");
    do_ref(mk(1, 0, 0), "R8 entry invalid after flush");
    idle(2);

    // R6: sweep of 4 lines into 3-way set3
    for (int p = 0; p < 3; p++)
      for (int l = 0; l < 4; l++) do_ref(mk(20 + l, 3, 0), "R6 cyclic sweep");
    idle(2);
    check("R6 sweep no hits", int'(c_hit), 0);
    check_counts("R7 after sweep");

    // R9: saturate the counters
    for (int i = 0; i < 60; i++) do_ref(mk(30 + (i % 5), 1, 0), "R9 load");
    idle(2);
    check("R9 ref saturated", int'(c_ref), CMAX);
    check_counts("R9 saturation");

    idle(2);
    finish_run();
  end
endmodule